// File: doc/BRIEF.md
# Multi-Consumer Tile Slot Ring

This block controls a ring of tile slots held in a scratchpad. A single producer claims the tail slot with a push request. The block returns that slot's scratchpad address, and a bulk transfer engine outside the block fills the slot. The engine reports each landed transfer with a one-cycle completion pulse. That pulse is the producer's arrival on the slot's barrier. It never stalls the producer, which may claim further free slots before any consumer has read the first one.

Each consumer has its own read position in the ring. A peek returns the address of the consumer's next slot and leaves it in place. A pop consumes that slot for the requesting consumer only. A request on a slot whose transfer has not landed raises a stall, which is the blocking half of the barrier. A slot goes back to the free pool once every registered consumer has popped it.

Software-visible geometry is set through a configuration write, and only while the ring holds no slots. The geometry is the base address, the tile stride, the slot count and the set of registered consumers.

Top module: `tile_slot_ring`

## Requirements
- R1: After reset, `level` is 0, `prod_landed` is 1, no consumer request is ready, and the geometry is 8 slots, base 0, stride `RST_TILE`, with every consumer registered.
- R2: A push with the ring not full raises `push_ack` in the same cycle. `push_addr` is base + tail × stride. The tail then advances by one, modulo the slot count.
- R3: A push while `level` equals the slot count is held (`push_ack` 0). This holds even in the cycle in which the last pop frees a slot. The freed slot is available from the next cycle.
- R4: A `xfer_done` pulse moves the oldest slot still awaiting its transfer (in push order) to the readable state. A pulse arriving when no transfer is outstanding has no effect.
- R5: `prod_landed` is 1 exactly when no pushed slot still awaits its completion pulse.
- R6: A peek (`cons_req` with `cons_pop` 0) on a readable slot gives `cons_ready` 1 and `cons_addr` = base + slot × stride. It changes no state.
- R7: A ready pop advances only the requesting consumer's position. The slot is freed, and `level` drops by one on the next cycle, only when all registered consumers have popped it.
- R8: `cons_stall` is raised and nothing changes when a consumer requests a slot that is still filling or empty, or one it has already popped, or when the consumer is not registered.
- R9: A configuration write is accepted (`cfg_ack`) only while `level` is 0. It then loads the base, stride, slot count (`cfg_slots_m1` + 1) and consumer mask, and it resets the head, tail, completion and consumer positions to slot 0. A write while the ring is not empty is ignored. A write in the same cycle as a push blocks that push.
- R10: `level` equals the number of slots that are filling or readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write request |
| cfg_base | input | AW | New ring base address |
| cfg_tile | input | AW | New tile stride in address units |
| cfg_slots_m1 | input | PW | New slot count minus one |
| cfg_cons | input | NUM_CONS | New registered-consumer mask |
| cfg_ack | output | 1 | Configuration accepted this cycle |
| push_req | input | 1 | Producer claims the tail slot |
| push_ack | output | 1 | Claim accepted this cycle |
| push_addr | output | AW | Scratchpad address of the tail slot |
| xfer_done | input | 1 | Transfer landed for the oldest outstanding slot |
| prod_landed | output | 1 | No transfer outstanding |
| cons_req | input | 1 | Consumer request valid |
| cons_pop | input | 1 | 1 = pop, 0 = peek |
| cons_id | input | CW | Requesting consumer index |
| cons_ready | output | 1 | Requested slot is readable for this consumer |
| cons_stall | output | 1 | Request blocked on an unready slot |
| cons_addr | output | AW | Address of the consumer's next slot |
| level | output | NW | Number of occupied slots |

## Verification
Two collisions matter most here. The first is a push against a full ring in the same cycle as the final pop that frees the head slot. The bench fills the ring, has the last registered consumer pop the head while the producer pushes, and expects the push held with acceptance one cycle later at the base address. The second is a completion pulse landing on a slot in the same cycle that a consumer asks for it. The bench expects a stall in that cycle and readiness in the next. Long stretches of mixed random traffic then recreate both collisions against the reference model, which is compared on every clock.

// File: rtl/tile_slot_ring.sv
module tile_slot_ring #(
  parameter int MAX_SLOTS = 8,
  parameter int NUM_CONS  = 4,
  parameter int AW        = 16,
  parameter int RST_TILE  = 64,
  localparam int PW = $clog2(MAX_SLOTS),
  localparam int CW = $clog2(NUM_CONS),
  localparam int NW = $clog2(MAX_SLOTS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [AW-1:0]       cfg_base,
  input  logic [AW-1:0]       cfg_tile,
  input  logic [PW-1:0]       cfg_slots_m1,
  input  logic [NUM_CONS-1:0] cfg_cons,
  output logic                cfg_ack,
  input  logic                push_req,
  output logic                push_ack,
  output logic [AW-1:0]       push_addr,
  input  logic                xfer_done,
  output logic                prod_landed,
  input  logic                cons_req,
  input  logic                cons_pop,
  input  logic [CW-1:0]       cons_id,
  output logic                cons_ready,
  output logic                cons_stall,
  output logic [AW-1:0]       cons_addr,
  output logic [NW-1:0]       level
);

  typedef enum logic [1:0] {S_EMPTY, S_FILL, S_READY} slot_st_t;

  slot_st_t            st     [MAX_SLOTS];
  logic [NUM_CONS-1:0] done_m [MAX_SLOTS];
  logic [PW-1:0]       rd     [NUM_CONS];
  logic [PW-1:0]       head, tail, fill, nslots_m1;
  logic [AW-1:0]       base, tile;
  logic [NUM_CONS-1:0] regm;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p, input logic [PW-1:0] lim);
    return (p == lim) ? '0 : p + 1'b1;
  endfunction

  logic                full, land, pop_go, rel;
  logic [PW-1:0]       cslot;
  logic [NUM_CONS-1:0] cbit, newm;

  assign full       = (level == NW'(nslots_m1) + NW'(1));
  assign cfg_ack    = cfg_we && (level == '0);
  assign push_ack   = push_req && !full && !cfg_we;
  assign push_addr  = base + AW'(tail) * tile;
  assign land       = xfer_done && (st[fill] == S_FILL);
  assign cslot      = rd[cons_id];
  assign cbit       = NUM_CONS'(1) << cons_id;
  assign cons_ready = regm[cons_id] && (st[cslot] == S_READY) && !done_m[cslot][cons_id];
  assign cons_stall = cons_req && !cons_ready;
  assign cons_addr  = base + AW'(cslot) * tile;
  assign pop_go     = cons_req && cons_pop && cons_ready;
  assign newm       = done_m[cslot] | cbit;
  assign rel        = pop_go && (newm == regm);

  always_comb begin
    prod_landed = 1'b1;
    for (int i = 0; i < MAX_SLOTS; i++)
      if (st[i] == S_FILL) prod_landed = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_SLOTS; i++) begin
        st[i]     <= S_EMPTY;
        done_m[i] <= '0;
      end
      for (int c = 0; c < NUM_CONS; c++) rd[c] <= '0;
      head      <= '0;
      tail      <= '0;
      fill      <= '0;
      nslots_m1 <= PW'(MAX_SLOTS - 1);
      base      <= '0;
      tile      <= AW'(RST_TILE);
      regm      <= '1;
      level     <= '0;
    end else begin
      if (cfg_ack) begin
        base      <= cfg_base;
        tile      <= cfg_tile;
        nslots_m1 <= cfg_slots_m1;
        regm      <= cfg_cons;
        head      <= '0;
        tail      <= '0;
        fill      <= '0;
        for (int c = 0; c < NUM_CONS; c++) rd[c] <= '0;
      end
      if (push_ack) begin
        st[tail] <= S_FILL;
        tail     <= nxt(tail, nslots_m1);
      end
      if (land) begin
        st[fill] <= S_READY;
        fill     <= nxt(fill, nslots_m1);
      end
      if (pop_go) begin
        rd[cons_id] <= nxt(cslot, nslots_m1);
        if (rel) begin
          st[cslot]     <= S_EMPTY;
          done_m[cslot] <= '0;
          head          <= nxt(head, nslots_m1);
        end else begin
          done_m[cslot] <= newm;
        end
      end
      level <= level + NW'(push_ack) - NW'(rel);
    end
  end

endmodule

// File: rtl/tile_slot_ring_chk.sv
module tile_slot_ring_chk #(
  parameter int MAX_SLOTS = 8,
  parameter int NW        = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_ack,
  input logic          push_req,
  input logic          push_ack,
  input logic          prod_landed,
  input logic          cons_ready,
  input logic [NW-1:0] level
);

  // R2
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ack |-> push_req);

  // R10
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= NW'(MAX_SLOTS));

  // R10
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !push_ack |=> level <= $past(level));

  // R2
  push_occupies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ack |=> level != '0);

  // R8
  empty_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level == '0 |-> !cons_ready);

  // R5
  landed_vs_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prod_landed |-> level != '0);

  // R9
  cfg_leaves_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ack |=> (level == '0) && prod_landed);

endmodule

bind tile_slot_ring tile_slot_ring_chk #(.MAX_SLOTS(MAX_SLOTS), .NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_ack(cfg_ack), .push_req(push_req),
  .push_ack(push_ack), .prod_landed(prod_landed), .cons_ready(cons_ready),
  .level(level)
);

// File: tb/tile_slot_ring_tb.sv
module tile_slot_ring_tb;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [15:0] cfg_base = 0, cfg_tile = 0;
  logic [2:0]  cfg_slots_m1 = 0;
  logic [3:0]  cfg_cons = 0;
  logic        cfg_ack, push_req = 0, push_ack, xfer_done = 0, prod_landed;
  logic [15:0] push_addr, cons_addr;
  logic        cons_req = 0, cons_pop = 0, cons_ready, cons_stall;
  logic [1:0]  cons_id = 0;
  logic [3:0]  level;

  always #10 clk = ~clk;

  tile_slot_ring u_dut (.*);

  int tests = 0, fails = 0;

  int m_st[8], m_done[8], m_rd[4];
  int m_tail, m_n, m_base, m_tile, m_reg, m_level;
  int fillq[$];

  task automatic model_reset();
    foreach (m_st[i]) begin m_st[i] = 0; m_done[i] = 0; end
    foreach (m_rd[i]) m_rd[i] = 0;
    m_tail = 0; m_n = 8; m_base = 0; m_tile = 64; m_reg = 15; m_level = 0;
    fillq.delete();
  endtask

  task automatic step(input string tag);
    int cs, e_lvl;
    bit e_cfg, e_pa, e_land, e_rdy, e_stall, e_landed;
    int e_paddr, e_caddr;
    #5;
    cs       = m_rd[cons_id];
    e_cfg    = cfg_we && m_level == 0;
    e_pa     = push_req && m_level != m_n && !cfg_we;
    e_paddr  = (m_base + m_tail * m_tile) & 16'hFFFF;
    e_land   = xfer_done && fillq.size() > 0;
    e_landed = fillq.size() == 0;
    e_rdy    = m_reg[cons_id] && m_st[cs] == 2 && !m_done[cs][cons_id];
    e_stall  = cons_req && !e_rdy;
    e_caddr  = (m_base + cs * m_tile) & 16'hFFFF;
    e_lvl    = m_level;
    tests++;
    if (cfg_ack !== e_cfg || push_ack !== e_pa || push_addr !== e_paddr[15:0] ||
        prod_landed !== e_landed || cons_ready !== e_rdy || cons_stall !== e_stall ||
        cons_addr !== e_caddr[15:0] || level !== e_lvl[3:0]) begin
      fails++;
      $display("FAIL %s t=%0t act cfg=%b ack=%b pa=%h ld=%b rdy=%b st=%b ca=%h lv=%0d exp cfg=%b ack=%b pa=%h ld=%b rdy=%b st=%b ca=%h lv=%0d",
        tag, $time, cfg_ack, push_ack, push_addr, prod_landed, cons_ready, cons_stall, cons_addr, level,
        e_cfg, e_pa, e_paddr[15:0], e_landed, e_rdy, e_stall, e_caddr[15:0], e_lvl);
    end
    if (e_cfg) begin
      m_base = cfg_base; m_tile = cfg_tile; m_n = cfg_slots_m1 + 1; m_reg = cfg_cons;
      m_tail = 0;
      foreach (m_rd[i]) m_rd[i] = 0;
    end
    if (e_land) m_st[fillq.pop_front()] = 2;
    if (e_pa) begin
      m_st[m_tail] = 1; fillq.push_back(m_tail);
      m_tail = (m_tail + 1) % m_n;
      m_level++;
    end
    if (cons_req && cons_pop && e_rdy) begin
      m_rd[cons_id] = (cs + 1) % m_n;
      m_done[cs] |= (1 << cons_id);
      if (m_done[cs] == m_reg) begin m_st[cs] = 0; m_done[cs] = 0; m_level--; end
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    cfg_we = 0; push_req = 0; xfer_done = 0; cons_req = 0; cons_pop = 0;
  endtask

  task automatic cfg(input int b, input int t, input int n, input int m);
    cfg_base = 16'(b); cfg_tile = 16'(t); cfg_slots_m1 = 3'(n - 1); cfg_cons = 4'(m); cfg_we = 1;
  endtask

  task automatic req(input int id, input bit pop);
    cons_req = 1; cons_id = 2'(id); cons_pop = pop;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(); step("R1");
    req(0, 0); step("R1");
    idle();
    cfg('h1000, 'h40, 4, 'b0111); step("R9");
    idle(); req(0, 0); step("R8");
    idle(); push_req = 1; repeat (4) step("R2");
    step("R3");
    idle(); step("R5");
    req(0, 0); step("R8");
    idle(); xfer_done = 1; req(0, 0); step("R4");
    idle(); req(0, 0); step("R6");
    req(3, 1); step("R8");
    req(0, 1); step("R7");
    req(1, 1); step("R7");
    req(0, 0); step("R8");
    req(0, 1); step("R8");
    idle(); xfer_done = 1; repeat (3) step("R4");
    step("R4");
    idle(); step("R5");
    cfg('h2000, 'h10, 2, 'b0001); step("R9");
    idle(); req(2, 1); push_req = 1; step("R3");
    idle(); push_req = 1; step("R2");
    idle(); step("R10");
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 3; c++) begin idle(); req(c, 1); step("R7"); end
    end
    idle(); xfer_done = 1; step("R4");
    for (int c = 0; c < 3; c++) begin idle(); req(c, 1); step("R7"); end
    idle(); cfg('h0300, 'h20, 3, 'b1001); push_req = 1; step("R9");
    for (int k = 0; k < 6000; k++) begin
      idle();
      push_req  = ($urandom_range(0, 99) < 55);
      xfer_done = ($urandom_range(0, 99) < 45);
      if ($urandom_range(0, 99) < 70) req($urandom_range(0, 3), $urandom_range(0, 3) != 0);
      if ($urandom_range(0, 99) < 4)
        cfg($urandom_range(0, 'hFFFF), $urandom_range(1, 'h200), $urandom_range(1, 8),
            $urandom_range(0, 15) | (1 << $urandom_range(0, 3)));
      step("R10");
    end
    idle(); step("R10");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule